// File: doc/BRIEF.md
# Asynchronous SRAM Controller

This block connects a clocked request/response port to an external asynchronous static RAM holding 262,144 bytes behind an 18-bit address. A user issues one read or one write at a time with a valid/ready handshake. Writes complete silently. Reads return one byte, marked by a single-cycle valid strobe. On the memory side the controller drives the address, an active-low and an active-high select, an active-low write strobe, an active-low read (output) enable, and a split data bus made of an output, a drive enable and an input.

Every phase length is a whole number of clock cycles. The controller derives each length at elaboration from a clock-period parameter in nanoseconds and a speed-grade parameter that picks one of two sets of minimum times. A write is closed by the write strobe rising while both selects stay active. The read path captures data on the final counted access cycle and then leaves the bus idle long enough for the memory to release it.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset and whenever idle, the controller shows mem_sel_n=1, mem_sel=0, mem_wr_n=1, mem_rd_n=1 and mem_dq_oe=0, with req_ready=1.
- R2: req_ready is high only in the idle state. A request is taken on a clock edge where req_valid and req_ready are both high, with req_write=1 meaning write and 0 meaning read.
- R3: A write holds mem_wr_n low for exactly WP cycles, where WP is the largest of the cycle counts for the write-pulse, address-to-end and data-setup minimums. Address and write data stay stable throughout.
- R4: A write ends with mem_wr_n rising while mem_sel_n=0 and mem_sel=1. The selects drop after WREC further cycles, where WREC = max(1, cycles(write cycle) - WP), and req_ready then returns.
- R5: mem_rd_n stays high for the whole write. mem_dq_oe is high from the cycle mem_wr_n falls through exactly one cycle after it rises, and low at every other time.
- R6: A read holds both selects active and mem_rd_n low for exactly RD cycles, RD = max(cycles(access), cycles(output-enable access)), with mem_wr_n high and mem_dq_oe low. mem_dq_in is sampled at the edge that ends the last of these cycles.
- R7: rsp_valid is high for exactly one cycle, in the first cycle after the read enable and the selects go inactive, and carries the sampled byte. req_ready returns after HZ cycles, HZ = cycles(output release time).
- R8: GRADE=0 uses minimums of 40/45/25/55 ns (write pulse, address-to-end, data setup, write cycle) and 55/25/20 ns (access, output-enable access, release). GRADE=1 uses 50/60/30/70 and 70/35/25 ns. cycles(t) = ceil(t / CLK_NS), never below 1.
- R9: Asserting rst_n low in the middle of a write returns all memory controls at once to the idle values of R1. Later requests then work normally.
- R10: A byte written at an address is returned by a later read of that address, including at the lowest and highest addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write byte |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | DATA_W | Read byte |
| mem_addr | output | ADDR_W | Memory address |
| mem_sel_n | output | 1 | Active-low memory select |
| mem_sel | output | 1 | Active-high memory select |
| mem_wr_n | output | 1 | Active-low write strobe |
| mem_rd_n | output | 1 | Active-low memory output enable |
| mem_dq_out | output | DATA_W | Data driven toward the memory |
| mem_dq_oe | output | 1 | Controller drives the data bus |
| mem_dq_in | input | DATA_W | Data returned by the memory |

## Verification
The hardest case to reach is a read that samples one cycle too early. The ports look identical in that case unless the memory model reports the difference. The bench model therefore returns a poison byte until the read enable has been low for the full counted access time, so an early capture shows up as a data mismatch. A reset that arrives in the middle of a write strobe is reached by launching a write and pulling reset two cycles later, then running a normal read. A second instance set to the slow grade shows that the grade parameter changes the phase lengths.

// File: rtl/sram_async_pkg.sv
`timescale 1ns/1ps
package sram_async_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WR_PULSE,
      ST_WR_REC,
      ST_RD_ACC,
      ST_RD_TURN
   } sram_state_t;

   // minimum times in ns for one speed grade
   typedef struct packed {
      int unsigned wr_pulse;
      int unsigned addr_to_end;
      int unsigned data_setup;
      int unsigned wr_cycle;
      int unsigned rd_access;
      int unsigned oe_access;
      int unsigned oe_release;
   } grade_ns_t;

   function automatic grade_ns_t grade_ns(input int grade);
      grade_ns_t g;
      if (grade == 0) g = '{wr_pulse:40, addr_to_end:45, data_setup:25, wr_cycle:55,
                            rd_access:55, oe_access:25, oe_release:20};
      else            g = '{wr_pulse:50, addr_to_end:60, data_setup:30, wr_cycle:70,
                            rd_access:70, oe_access:35, oe_release:25};
      return g;
   endfunction

   function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per);
      int unsigned c;
      c = (ns + per - 1) / per;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   function automatic int unsigned wp_cycles(input int grade, input int unsigned per);
      grade_ns_t g;
      g = grade_ns(grade);
      return max_u(ns_to_cyc(g.wr_pulse, per),
                   max_u(ns_to_cyc(g.addr_to_end, per), ns_to_cyc(g.data_setup, per)));
   endfunction

   function automatic int unsigned wrec_cycles(input int grade, input int unsigned per);
      grade_ns_t g;
      int unsigned wc, wp;
      g  = grade_ns(grade);
      wc = ns_to_cyc(g.wr_cycle, per);
      wp = wp_cycles(grade, per);
      return (wc > wp + 1) ? (wc - wp) : 1;
   endfunction

   function automatic int unsigned rd_cycles(input int grade, input int unsigned per);
      grade_ns_t g;
      g = grade_ns(grade);
      return max_u(ns_to_cyc(g.rd_access, per), ns_to_cyc(g.oe_access, per));
   endfunction

   function automatic int unsigned hz_cycles(input int grade, input int unsigned per);
      grade_ns_t g;
      g = grade_ns(grade);
      return ns_to_cyc(g.oe_release, per);
   endfunction

endpackage

// File: rtl/sram_async_dwell.sv
`timescale 1ns/1ps
module sram_async_dwell #(
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             done
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (load)         cnt_q <= load_val;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == '0);
endmodule

// File: rtl/sram_async_seq.sv
`timescale 1ns/1ps
module sram_async_seq
   import sram_async_pkg::*;
#(
   parameter int unsigned N_WP   = 5,
   parameter int unsigned N_WREC = 1,
   parameter int unsigned N_RD   = 6,
   parameter int unsigned N_HZ   = 2,
   parameter int          CNT_W  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_write,
   input  logic             dwell_done,
   output logic             dwell_load,
   output logic [CNT_W-1:0] dwell_val,
   output logic             req_ready,
   output logic             capture,
   output logic             sel_act,
   output logic             wr_n,
   output logic             rd_n,
   output logic             dq_oe,
   output logic             rsp_valid
);
   sram_state_t st_q, st_d;

   always_comb begin
      st_d       = st_q;
      dwell_load = 1'b0;
      dwell_val  = '0;
      capture    = 1'b0;
      unique case (st_q)
         ST_IDLE: if (req_valid) begin
            dwell_load = 1'b1;
            if (req_write) begin
               st_d      = ST_WR_PULSE;
               dwell_val = CNT_W'(N_WP - 1);
            end else begin
               st_d      = ST_RD_ACC;
               dwell_val = CNT_W'(N_RD - 1);
            end
         end
         ST_WR_PULSE: if (dwell_done) begin
            st_d       = ST_WR_REC;
            dwell_load = 1'b1;
            dwell_val  = CNT_W'(N_WREC - 1);
         end
         ST_WR_REC: if (dwell_done) st_d = ST_IDLE;
         ST_RD_ACC: if (dwell_done) begin
            st_d       = ST_RD_TURN;
            dwell_load = 1'b1;
            dwell_val  = CNT_W'(N_HZ - 1);
            capture    = 1'b1;
         end
         ST_RD_TURN: if (dwell_done) st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   // memory controls are registered from the next state so they never glitch
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         sel_act   <= 1'b0;
         wr_n      <= 1'b1;
         rd_n      <= 1'b1;
         dq_oe     <= 1'b0;
         rsp_valid <= 1'b0;
      end else begin
         st_q      <= st_d;
         sel_act   <= (st_d == ST_WR_PULSE) || (st_d == ST_WR_REC) || (st_d == ST_RD_ACC);
         wr_n      <= (st_d != ST_WR_PULSE);
         rd_n      <= (st_d != ST_RD_ACC);
         dq_oe     <= (st_d == ST_WR_PULSE) || ((st_q == ST_WR_PULSE) && (st_d == ST_WR_REC));
         rsp_valid <= capture;
      end
   end

   assign req_ready = (st_q == ST_IDLE);
endmodule

// File: rtl/sram_async_datapath.sv
`timescale 1ns/1ps
module sram_async_datapath #(
   parameter int ADDR_W = 18,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              capture,
   input  logic [DATA_W-1:0] mem_dq_in,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic [DATA_W-1:0] rsp_rdata
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_addr   <= '0;
         mem_dq_out <= '0;
      end else if (accept) begin
         mem_addr   <= req_addr;
         mem_dq_out <= req_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rsp_rdata <= '0;
      else if (capture) rsp_rdata <= mem_dq_in;
   end
endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
module sram_async_ctrl
   import sram_async_pkg::*;
#(
   parameter int CLK_NS = 10,
   parameter int GRADE  = 0,
   parameter int ADDR_W = 18,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_sel_n,
   output logic              mem_sel,
   output logic              mem_wr_n,
   output logic              mem_rd_n,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in
);
   localparam int unsigned N_WP   = wp_cycles(GRADE, CLK_NS);
   localparam int unsigned N_WREC = wrec_cycles(GRADE, CLK_NS);
   localparam int unsigned N_RD   = rd_cycles(GRADE, CLK_NS);
   localparam int unsigned N_HZ   = hz_cycles(GRADE, CLK_NS);
   localparam int unsigned N_MAX  = max_u(max_u(N_WP, N_WREC), max_u(N_RD, N_HZ));
   localparam int          CNT_W  = (N_MAX > 1) ? $clog2(N_MAX) : 1;

   if (CLK_NS < 1) begin : g_bad_clk
      $error("sram_async_ctrl: CLK_NS must be at least 1");
   end
   if (GRADE != 0 && GRADE != 1) begin : g_bad_grade
      $error("sram_async_ctrl: GRADE must be 0 or 1");
   end
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("sram_async_ctrl: widths must be positive");
   end

   logic             dwell_load, dwell_done, capture, sel_act;
   logic [CNT_W-1:0] dwell_val;

   sram_async_dwell #(.CNT_W(CNT_W)) u_dwell (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (dwell_load),
      .load_val (dwell_val),
      .done     (dwell_done)
   );

   sram_async_seq #(
      .N_WP(N_WP), .N_WREC(N_WREC), .N_RD(N_RD), .N_HZ(N_HZ), .CNT_W(CNT_W)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_write  (req_write),
      .dwell_done (dwell_done),
      .dwell_load (dwell_load),
      .dwell_val  (dwell_val),
      .req_ready  (req_ready),
      .capture    (capture),
      .sel_act    (sel_act),
      .wr_n       (mem_wr_n),
      .rd_n       (mem_rd_n),
      .dq_oe      (mem_dq_oe),
      .rsp_valid  (rsp_valid)
   );

   sram_async_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept     (req_valid && req_ready),
      .req_addr   (req_addr),
      .req_wdata  (req_wdata),
      .capture    (capture),
      .mem_dq_in  (mem_dq_in),
      .mem_addr   (mem_addr),
      .mem_dq_out (mem_dq_out),
      .rsp_rdata  (rsp_rdata)
   );

   assign mem_sel_n = ~sel_act;
   assign mem_sel   = sel_act;
endmodule

// File: rtl/sram_async_ctrl_chk.sv
`timescale 1ns/1ps
module sram_async_ctrl_chk
   import sram_async_pkg::*;
#(
   parameter int CLK_NS = 10,
   parameter int GRADE  = 0,
   parameter int ADDR_W = 18,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_sel_n,
   input logic              mem_sel,
   input logic              mem_wr_n,
   input logic              mem_rd_n,
   input logic [DATA_W-1:0] mem_dq_out,
   input logic              mem_dq_oe
);
   localparam int unsigned N_WP = wp_cycles(GRADE, CLK_NS);
   localparam int unsigned N_RD = rd_cycles(GRADE, CLK_NS);

   int unsigned wr_low_cnt, rd_low_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_low_cnt <= 0;
         rd_low_cnt <= 0;
      end else begin
         wr_low_cnt <= mem_wr_n ? 0 : wr_low_cnt + 1;
         rd_low_cnt <= mem_rd_n ? 0 : rd_low_cnt + 1;
      end
   end

   a_r1_idle_outputs: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (mem_sel_n && !mem_sel && mem_wr_n && mem_rd_n && !mem_dq_oe));

   a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   a_r3_pulse_length: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_wr_n) |-> (wr_low_cnt == N_WP));

   a_r3_stable_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_wr_n && !$past(mem_wr_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

   a_r4_end_by_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_wr_n) |-> (!mem_sel_n && mem_sel && mem_dq_oe));

   a_r5_no_read_in_write: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_wr_n |-> (mem_rd_n && mem_dq_oe));

   a_r5_drive_only_selected: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> (mem_rd_n && !mem_sel_n));

   a_r6_access_length: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_rd_n) |-> (rd_low_cnt == N_RD && rsp_valid));

   a_r6_read_selected: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_rd_n |-> (!mem_sel_n && mem_sel && mem_wr_n && !mem_dq_oe));

   a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);
endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(
   .CLK_NS(CLK_NS), .GRADE(GRADE), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .rsp_valid(rsp_valid), .mem_addr(mem_addr), .mem_sel_n(mem_sel_n),
   .mem_sel(mem_sel), .mem_wr_n(mem_wr_n), .mem_rd_n(mem_rd_n),
   .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe)
);

// File: tb/sram_async_ctrl_tb_top.sv
`timescale 1ns/1ps
module sram_async_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;

   function automatic int cdiv(input int ns);
      int c;
      c = (ns + CLK_PERIOD - 1) / CLK_PERIOD;
      return (c < 1) ? 1 : c;
   endfunction
   function automatic int mx(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   // fast grade (R8): 40/45/25/55 write, 55/25/20 read
   localparam int F_WP   = mx(cdiv(40), mx(cdiv(45), cdiv(25)));
   localparam int F_WREC = mx(1, cdiv(55) - F_WP);
   localparam int F_RD   = mx(cdiv(55), cdiv(25));
   localparam int F_HZ   = cdiv(20);
   // slow grade (R8): 50/60/30 write, 70/35 read
   localparam int S_WP   = mx(cdiv(50), mx(cdiv(60), cdiv(30)));
   localparam int S_RD   = mx(cdiv(70), cdiv(35));

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   int n_cmp = 0;
   int n_bad = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // ---------------- fast-grade instance ----------------
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [17:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic        req_ready, rsp_valid;
   logic [7:0]  rsp_rdata;
   logic [17:0] mem_addr;
   logic        mem_sel_n, mem_sel, mem_wr_n, mem_rd_n, mem_dq_oe;
   logic [7:0]  mem_dq_out;
   logic [7:0]  mem_dq_in;

   sram_async_ctrl #(.CLK_NS(CLK_PERIOD), .GRADE(0)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
      .mem_sel_n(mem_sel_n), .mem_sel(mem_sel), .mem_wr_n(mem_wr_n),
      .mem_rd_n(mem_rd_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
      .mem_dq_in(mem_dq_in)
   );

   // memory model: write commits when the overlap ends; read data appears
   // only after the full counted access time, poison (EE) before that
   logic [7:0] mem_m [int];
   int rd_age = 0;
   wire wr_ov = !mem_wr_n && !mem_sel_n && mem_sel;
   wire rd_on = !mem_rd_n && !mem_sel_n && mem_sel;

   always @(negedge wr_ov) if (rst_n === 1'b1) mem_m[int'(mem_addr)] = mem_dq_out;

   always @(posedge clk) rd_age <= rd_on ? rd_age + 1 : 0;

   always @* begin
      if (rd_on && rd_age >= F_RD - 1)
         mem_dq_in = mem_m.exists(int'(mem_addr)) ? mem_m[int'(mem_addr)] : 8'h00;
      else
         mem_dq_in = 8'hEE;
   end

   // ---------------- slow-grade instance ----------------
   logic        s_valid = 1'b0, s_write = 1'b0;
   logic [17:0] s_addr = '0;
   logic [7:0]  s_wdata = '0;
   logic        s_ready, s_rsp_valid;
   logic [7:0]  s_rsp_rdata, s_dq_out;
   logic [17:0] s_mem_addr;
   logic        s_sel_n, s_sel, s_wr_n, s_rd_n, s_dq_oe;

   sram_async_ctrl #(.CLK_NS(CLK_PERIOD), .GRADE(1)) dut_slow (
      .clk(clk), .rst_n(rst_n), .req_valid(s_valid), .req_ready(s_ready),
      .req_write(s_write), .req_addr(s_addr), .req_wdata(s_wdata),
      .rsp_valid(s_rsp_valid), .rsp_rdata(s_rsp_rdata), .mem_addr(s_mem_addr),
      .mem_sel_n(s_sel_n), .mem_sel(s_sel), .mem_wr_n(s_wr_n),
      .mem_rd_n(s_rd_n), .mem_dq_out(s_dq_out), .mem_dq_oe(s_dq_oe),
      .mem_dq_in(8'h5A)
   );

   // ---------------- scoreboard ----------------
   logic [7:0] shadow [int];
   logic [7:0] exp_q [$];
   logic       rsp_prev = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (rsp_valid) begin
            chk(!rsp_prev, "R7", "strobe longer than one cycle", 1, 0);
            if (exp_q.size() == 0) chk(1'b0, "R7", "unexpected read strobe", 1, 0);
            else begin
               logic [7:0] e;
               e = exp_q.pop_front();
               chk(rsp_rdata == e, "R10", "read data", rsp_rdata, e);
            end
         end
         rsp_prev = rsp_valid;
      end else rsp_prev = 1'b0;
   end

   // ---------------- driver tasks (called at a falling edge) ----------------
   task automatic do_write(input logic [17:0] a, input logic [7:0] d);
      int n, m;
      chk(req_ready, "R2", "ready before write", req_ready, 1);
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0; req_addr = ~a; req_wdata = ~d;
      shadow[int'(a)] = d;
      n = 0;
      while (!mem_wr_n && n < 100) begin
         chk(mem_addr == a && mem_dq_out == d, "R3", "address/data in pulse", mem_dq_out, d);
         chk(mem_rd_n && mem_dq_oe, "R5", "read enable high, bus driven", {mem_rd_n, mem_dq_oe}, 3);
         chk(!req_ready, "R2", "ready low while busy", req_ready, 0);
         n++;
         @(negedge clk);
      end
      chk(n == F_WP, "R3", "write strobe cycles", n, F_WP);
      chk(!mem_sel_n && mem_sel, "R4", "selects active at strobe end", {mem_sel_n, mem_sel}, 1);
      chk(mem_dq_oe, "R5", "data held one cycle after strobe", mem_dq_oe, 1);
      m = 0;
      while (!req_ready && m < 100) begin m++; @(negedge clk); end
      chk(m == F_WREC, "R4", "recovery cycles", m, F_WREC);
      chk(mem_sel_n && !mem_sel && !mem_dq_oe, "R1", "idle after write",
          {mem_sel_n, mem_sel, mem_dq_oe}, 4);
   endtask

   task automatic do_read(input logic [17:0] a);
      int n, m;
      chk(req_ready, "R2", "ready before read", req_ready, 1);
      req_valid = 1'b1; req_write = 1'b0; req_addr = a;
      exp_q.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00);
      @(negedge clk);
      req_valid = 1'b0; req_addr = ~a;
      n = 0;
      while (!mem_rd_n && n < 100) begin
         chk(!mem_sel_n && mem_sel && mem_wr_n && !mem_dq_oe, "R6", "read controls",
             {mem_sel_n, mem_sel, mem_wr_n, mem_dq_oe}, 6);
         n++;
         @(negedge clk);
      end
      chk(n == F_RD, "R6", "read enable cycles", n, F_RD);
      chk(rsp_valid && mem_sel_n, "R7", "strobe as selects drop", {rsp_valid, mem_sel_n}, 3);
      m = 0;
      while (!req_ready && m < 100) begin m++; @(negedge clk); end
      chk(m == F_HZ, "R7", "release cycles", m, F_HZ);
   endtask

   // ---------------- sequence ----------------
   initial begin : main
      repeat (3) @(negedge clk);
      chk(mem_sel_n && !mem_sel, "R1", "selects in reset", {mem_sel_n, mem_sel}, 2);
      chk(mem_wr_n && mem_rd_n, "R1", "strobes in reset", {mem_wr_n, mem_rd_n}, 3);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready && !mem_dq_oe && !rsp_valid, "R1", "idle after reset",
          {req_ready, mem_dq_oe, rsp_valid}, 4);

      do_read(18'h00010);
      do_write(18'h00000, 8'hA5);
      do_write(18'h3FFFF, 8'h5A);
      do_write(18'h12345, 8'h3C);
      do_read(18'h00000);
      do_read(18'h3FFFF);
      do_read(18'h12345);
      do_write(18'h12345, 8'hC3);
      do_read(18'h12345);
      for (int i = 0; i < 4; i++) do_write(18'(i * 18'h0F0F1), 8'(8'h11 * (i + 1)));
      for (int i = 3; i >= 0; i--) do_read(18'(i * 18'h0F0F1));

      // R9: reset in the middle of a write strobe
      req_valid = 1'b1; req_write = 1'b1; req_addr = 18'h2AAAA; req_wdata = 8'h77;
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
      chk(!mem_wr_n, "R9", "strobe low before reset", mem_wr_n, 0);
      rst_n = 1'b0;
      #1;
      chk(mem_wr_n && mem_rd_n && mem_sel_n && !mem_sel && !mem_dq_oe, "R9",
          "controls idle at reset", {mem_wr_n, mem_rd_n, mem_sel_n, mem_sel, mem_dq_oe}, 5'b11100);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready, "R9", "ready after reset", req_ready, 1);
      do_read(18'h3FFFF);

      // R8: slow grade lengths on the second instance
      begin
         int n;
         s_valid = 1'b1; s_write = 1'b1; s_addr = 18'h00042; s_wdata = 8'h99;
         @(negedge clk);
         s_valid = 1'b0;
         n = 0;
         while (!s_wr_n && n < 100) begin n++; @(negedge clk); end
         chk(n == S_WP, "R8", "slow write strobe cycles", n, S_WP);
         while (!s_ready) @(negedge clk);
         s_valid = 1'b1; s_write = 1'b0;
         @(negedge clk);
         s_valid = 1'b0;
         n = 0;
         while (!s_rd_n && n < 100) begin n++; @(negedge clk); end
         chk(n == S_RD, "R8", "slow read enable cycles", n, S_RD);
         chk(s_rsp_valid && s_rsp_rdata == 8'h5A, "R8", "slow read data", s_rsp_rdata, 8'h5A);
      end

      repeat (3) @(negedge clk);
      chk(exp_q.size() == 0, "R7", "all reads answered", exp_q.size(), 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule